// File: doc/BRIEF.md
# SPI Master Shift Datapath

This block is the data half of a 16-bit SPI master. A separate control state machine drives it through plain strobes. A load strobe latches a transmit word. A shift enable lets the block produce a serial clock from a periodic tick in the system-clock domain. On every falling serial-clock edge the block samples the slave's data input and moves the next transmit bit onto the output line, most significant bit first. The controller asserts chip select and keeps it low for the whole frame. No start bit is used, so the slave sees only clock edges.

A 4-bit bit counter tells the controller how far the transfer has progressed. The controller supplies the counter's enable and clear. The shift register also keeps its own tally of how many bits have moved. However late the controller reacts to the count, a loaded word never moves more than sixteen bits. When the controller signals finish, the received word is copied to the output and a one-cycle done pulse is raised. The received word has no back-pressure. It is held on the output until the next finish replaces it.

Each tick is one half period of the serial clock. For a 1 MHz serial clock the tick arrives at 2 MHz.

Top module: `spi_shift_datapath`

## Requirements
- R1: While reset is asserted and after it is released, sclk, mosi, bit_cnt, rx_data and done are all zero.
- R2: A load_en strobe captures tx_data, and its bit 15 appears on mosi on the following cycle, before any sclk edge. Before the first load after reset, shift_en produces no sclk edge.
- R3: While shift_en is high and the loaded word is not exhausted, sclk toggles on every tick, starting with a rising edge, so one sclk period is two ticks. While shift_en is low, sclk is low.
- R4: mosi changes only on a falling sclk transition or on a load, and the word leaves most significant bit first.
- R5: miso is sampled on each falling sclk transition and enters the receive register at bit 0, so the first bit received ends in bit 15.
- R6: One load allows exactly 16 falling edges. After that, sclk stays low however long shift_en remains high.
- R7: With cnt_en high, bit_cnt increases by one on each falling sclk transition and wraps from 15 to 0. With cnt_en low, bit_cnt holds.
- R8: cnt_clr zeroes bit_cnt at the next clock edge and takes priority over counting.
- R9: Dropping shift_en while sclk is low pauses the transfer without losing state. Raising it again continues with the next bit.
- R10: done is high for the cycle after each finish cycle. In that cycle rx_data shows the received word, and rx_data holds that value until the next finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per serial-clock half period |
| load_en | input | 1 | Latch tx_data into the shift register |
| shift_en | input | 1 | Allow serial clocking |
| cnt_en | input | 1 | Bit counter enable |
| cnt_clr | input | 1 | Synchronous bit counter clear |
| finish | input | 1 | End of frame, publish the received word |
| tx_data | input | 16 | Word to transmit |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| bit_cnt | output | 4 | Bit counter value |
| rx_data | output | 16 | Last received word |
| done | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
The embedded assertions check the following on every cycle:
- sclk is held low while clocking is not allowed, and it toggles on each allowed tick.
- mosi holds its value except on a load or a falling edge.
- The shift tally never exceeds sixteen.
- The counter clears, increments and holds correctly.
- Every finish produces done together with the latched word.

Only the bench scenarios can show the following:
- Bit order against a slave model, and the round-trip contents of the transmit and receive words.
- The exact sixteen-edge limit under an over-long shift phase.
- Pause and resume mid-word.
- Wrap of the counter over a whole frame.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned CNT_W_DEF  = 4;

  // width of a tally able to hold the value n
  function automatic int unsigned tally_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic sclk,
  output logic fall_evt
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sclk_q <= 1'b0;
    else if (!run)    sclk_q <= 1'b0;
    else if (tick)    sclk_q <= ~sclk_q;
  end

  // a falling edge is about to happen on this clock edge
  assign fall_evt = run & tick & sclk_q;
  assign sclk     = sclk_q;

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

  p_sclk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick |=> sclk_q != $past(sclk_q));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned WORD_W = spi_dp_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              fall_evt,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_shift,
  output logic              full
);
  localparam int unsigned TALLY_W = spi_dp_pkg::tally_width(WORD_W);
  localparam logic [TALLY_W-1:0] TALLY_MAX = TALLY_W'(WORD_W);

  logic [WORD_W-1:0]  tx_q;
  logic [WORD_W-1:0]  rx_q;
  logic [TALLY_W-1:0] tally_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      tally_q <= TALLY_MAX;   // nothing to shift until a load
    end else if (load_en) begin
      tx_q    <= load_word;
      tally_q <= '0;
    end else if (fall_evt) begin
      rx_q    <= {rx_q[WORD_W-2:0], miso};
      tx_q    <= {tx_q[WORD_W-2:0], 1'b0};
      tally_q <= tally_q + 1'b1;
    end
  end

  assign mosi     = tx_q[WORD_W-1];
  assign rx_shift = rx_q;
  assign full     = (tally_q == TALLY_MAX);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !fall_evt |=> mosi == $past(mosi));

  p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> mosi == $past(load_word[WORD_W-1]));

  p_tally_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> tally_q <= TALLY_MAX);
endmodule

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
  parameter int unsigned CNT_W = spi_dp_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_clr,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (cnt_clr)         cnt_q <= '0;
    else if (cnt_en && step)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_q == '0);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && step && !cnt_clr |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && step) && !cnt_clr |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/spi_shift_datapath.sv
module spi_shift_datapath #(
  parameter int unsigned WORD_W = spi_dp_pkg::WORD_W_DEF,
  parameter int unsigned CNT_W  = spi_dp_pkg::CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              finish,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] rx_data,
  output logic              done
);
  logic              fall_evt;
  logic              full;
  logic              run;
  logic [WORD_W-1:0] rx_shift;
  logic [WORD_W-1:0] rx_word_q;
  logic              done_q;

  // clocking stops by itself once the loaded word is exhausted
  assign run = shift_en & ~full & ~load_en;

  spi_sclk_gen u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (run),
    .sclk     (sclk),
    .fall_evt (fall_evt)
  );

  spi_shift_unit #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_word (tx_data),
    .fall_evt  (fall_evt),
    .miso      (miso),
    .mosi      (mosi),
    .rx_shift  (rx_shift),
    .full      (full)
  );

  spi_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_clr (cnt_clr),
    .step    (fall_evt),
    .count   (bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) rx_word_q <= rx_shift;
    end
  end

  assign rx_data = rx_word_q;
  assign done    = done_q;

  p_done_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && rx_data == $past(rx_shift));

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> !done && $stable(rx_data));

  p_no_clock_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !fall_evt);
endmodule

// File: tb/test_spi_shift_datapath.sv
module test_spi_shift_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load_en = 1'b0, shift_en = 1'b0, cnt_en = 1'b0, cnt_clr = 1'b0, finish = 1'b0;
  logic [15:0] tx_data = '0;
  logic        miso = 1'b0;
  logic        sclk, mosi, done;
  logic [3:0]  bit_cnt;
  logic [15:0] rx_data;

  int checks = 0, errors = 0;
  int rises = 0, falls = 0, cyc = 0, last_rise = 0, rise_gap = 0;
  logic        sclk_prev = 1'b0;
  logic [15:0] mosi_log = '0;
  logic [15:0] slave_sh = '0;

  spi_shift_datapath i_spi_shift_datapath (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en), .shift_en(shift_en),
    .cnt_en(cnt_en), .cnt_clr(cnt_clr), .finish(finish), .tx_data(tx_data), .miso(miso),
    .sclk(sclk), .mosi(mosi), .bit_cnt(bit_cnt), .rx_data(rx_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick source: one cycle in every TICK_DIV
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == TICK_DIV - 1);
      ph = (ph + 1) % TICK_DIV;
    end
  end

  // slave model and edge monitor, sampled just after the rising clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      if (sclk && !sclk_prev) begin
        if (rises > 0) rise_gap = cyc - last_rise;
        last_rise = cyc;
        rises++;
        mosi_log = {mosi_log[14:0], mosi};
        miso = slave_sh[15];
        slave_sh = {slave_sh[14:0], 1'b0};
      end
      if (!sclk && sclk_prev) falls++;
      sclk_prev = sclk;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected end)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    int guard = 0;
    while (falls < n && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic clear_count();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic load_word(input logic [15:0] w, input logic [15:0] sw);
    @(negedge clk);
    rises = 0; falls = 0; mosi_log = '0; slave_sh = sw; rise_gap = 0;
    tx_data = w; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    chk(mosi == w[15], "R2 msb on mosi after load", mosi, w[15]);
    chk(sclk == 1'b0, "R2 no sclk edge before shifting", sclk, 0);
  endtask

  task automatic publish(input logic [15:0] exp_word);
    @(negedge clk); finish = 1'b1;
    @(negedge clk); finish = 1'b0;
    chk(done == 1'b1, "R10 done after finish", done, 1);
    chk(rx_data == exp_word, "R5 received word", rx_data, exp_word);
    @(negedge clk);
    chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
    cycles(10);
    chk(rx_data == exp_word, "R10 rx_data held", rx_data, exp_word);
  endtask

  task automatic t_reset();
    cycles(3);
    chk(sclk == 0 && mosi == 0 && done == 0, "R1 reset outputs low", {sclk, mosi, done}, 0);
    chk(bit_cnt == 0 && rx_data == 0, "R1 reset counter and word", {bit_cnt, rx_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    chk(bit_cnt == 0 && rx_data == 0 && sclk == 0, "R1 after release", {bit_cnt, rx_data, sclk}, 0);
  endtask

  task automatic t_no_load();
    rises = 0;
    @(negedge clk); shift_en = 1'b1;
    cycles(40);
    chk(rises == 0, "R2 no sclk before first load", rises, 0);
    @(negedge clk); shift_en = 1'b0;
  endtask

  task automatic t_full(input logic [15:0] w, input logic [15:0] sw);
    clear_count();
    load_word(w, sw);
    @(negedge clk); cnt_en = 1'b1; shift_en = 1'b1;
    while (rises < 1) @(negedge clk);
    chk(falls == 0, "R3 first edge is rising", falls, 0);
    cycles(60 * TICK_DIV);   // far longer than sixteen bits need
    chk(rise_gap == 2 * TICK_DIV, "R3 sclk period two ticks", rise_gap, 2 * TICK_DIV);
    chk(rises == 16 && falls == 16, "R6 exactly sixteen edges", {rises[15:0], falls[15:0]}, {16'd16, 16'd16});
    chk(sclk == 1'b0, "R6 sclk low after word", sclk, 0);
    chk(mosi_log == w, "R4 mosi bit order", mosi_log, w);
    chk(bit_cnt == 0, "R7 count wraps after sixteen", bit_cnt, 0);
    @(negedge clk); shift_en = 1'b0; cnt_en = 1'b0;
    cycles(4);
    chk(sclk == 1'b0, "R3 sclk idle low", sclk, 0);
    publish(sw);
  endtask

  task automatic t_pause(input logic [15:0] w, input logic [15:0] sw);
    clear_count();
    load_word(w, sw);
    @(negedge clk); cnt_en = 1'b1; shift_en = 1'b1;
    wait_falls(5);
    shift_en = 1'b0;
    cycles(6 * TICK_DIV);
    chk(bit_cnt == 5, "R7 count after five edges", bit_cnt, 5);
    chk(falls == 5 && sclk == 0, "R9 paused stays low", {falls[15:0], 15'd0, sclk}, {16'd5, 16'd0});
    cnt_en = 1'b0; shift_en = 1'b1;
    wait_falls(8);
    chk(bit_cnt == 5, "R7 count holds when disabled", bit_cnt, 5);
    cnt_en = 1'b1; cnt_clr = 1'b1;
    wait_falls(10);
    chk(bit_cnt == 0, "R8 clear wins over counting", bit_cnt, 0);
    cnt_clr = 1'b0;
    cycles(40 * TICK_DIV);
    chk(bit_cnt == 6, "R7 counting after clear", bit_cnt, 6);
    chk(falls == 16 && mosi_log == w, "R9 resumed word intact", mosi_log, w);
    @(negedge clk); shift_en = 1'b0; cnt_en = 1'b0;
    publish(sw);
  endtask

  initial begin
    t_reset();
    t_no_load();
    t_full(16'hA5C3, 16'h3C5A);
    t_full(16'h8000, 16'hFFFE);
    t_full(16'hFFFF, 16'h0001);
    t_pause(16'h1234, 16'hBEEF);
    cycles(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule